// File: doc/BRIEF.md
# First-Press Lockout Arbiter

This block decides which contestant pressed first. It has N player inputs and N matching winner outputs. A capture register stores the inputs. While the open control `rst_n` is low, the register follows the synchronized inputs on every clock edge. Once `rst_n` goes high, the register keeps following the inputs only until any of its bits becomes 1. At that point a balanced OR tree over the captured bits raises `locked_o`, and the register freezes. Later presses then have no effect until `rst_n` is driven low again.

The OR tree gives every player the same logic depth, so no input is favoured. Presses that reach the register on the same clock edge are all reported together as a tie; the block does not choose between them. Each input passes through a synchronizer whose depth is set by a parameter (0 bypasses it). This lets mechanical switches or other asynchronous sources connect directly. A press must overlap at least one rising clock edge to be seen.

Top module: `first_press_arbiter`

## Requirements
- R1: While `rst_n` is low, `win_o` equals `press_i` delayed by SYNC_STAGES+1 clock edges. Bit i of `win_o` belongs to bit i of `press_i`.
- R2: `locked_o` is 1 exactly when at least one bit of `win_o` is 1, in every cycle, reset included.
- R3: With `rst_n` high and `locked_o` low, a press reaches `win_o` SYNC_STAGES+1 edges after it first overlaps an edge. `locked_o` rises in the same cycle.
- R4: While `rst_n` is high and `locked_o` is 1, `win_o` holds its value. New presses and released presses change nothing.
- R5: Presses that reach the register on the same edge all appear set in `win_o`, with no priority among them.
- R6: A press lasting a single clock cycle is captured.
- R7: If `win_o` is nonzero when `rst_n` rises, that value stays frozen from the first cycle after release.
- R8: Driving `rst_n` low with all inputs low clears `win_o` and `locked_o` after SYNC_STAGES+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low open control; low makes the register follow the inputs |
| press_i | input | N | Player buttons, one bit per player, active high |
| win_o | output | N | Captured winner vector; more than one bit set means a tie |
| locked_o | output | 1 | High while any captured bit is set |

## Verification
Directed patterns are used first. A lone press followed by a flood of later presses separates correct freezing from a register that keeps loading. Two bits rising together separate tie reporting from a priority pick. A one-cycle pulse tests the capture window. Holding a press across the release of `rst_n` checks lock-in at release. Constrained-random episodes then mix press patterns and reset timing, and every cycle is compared with a bench reference model. This exposes latency errors and bits that are dropped or wrongly merged.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  // Register loads when the arbiter is held open or nothing is captured yet.
  function automatic logic capture_enable(input logic open_n, input logic any_captured);
    return (!open_n) || (!any_captured);
  endfunction
endpackage

// File: rtl/fpa_sync.sv
module fpa_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        stg[0] <= async_in;
      end
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          stg[s] <= stg[s-1];
        end
      end
      assign sync_out = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fpa_or_tree.sv
module fpa_or_tree #(
  parameter int W = 4
) (
  input  logic [W-1:0] vec,
  output logic         any
);
  localparam int DEPTH = (W <= 1) ? 0 : $clog2(W);
  localparam int LEAVES = 1 << DEPTH;

  logic node [1:2*LEAVES-1];

  generate
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < W) begin : g_real
        assign node[LEAVES+i] = vec[i];
      end else begin : g_pad
        assign node[LEAVES+i] = 1'b0;
      end
    end
    for (genvar k = 1; k < LEAVES; k++) begin : g_node
      assign node[k] = node[2*k] | node[2*k+1];
    end
  endgenerate

  assign any = node[1];
endmodule

// File: rtl/fpa_capture.sv
module fpa_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/first_press_arbiter.sv
module first_press_arbiter #(
  parameter int N           = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] press_i,
  output logic [N-1:0] win_o,
  output logic         locked_o
);
  import fpa_pkg::*;

  logic [N-1:0] sync_q;
  logic [N-1:0] held_q;
  logic         any_held;
  logic         load_en;

  fpa_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (press_i),
    .sync_out (sync_q)
  );

  fpa_or_tree #(.W(N)) u_tree (
    .vec (held_q),
    .any (any_held)
  );

  assign load_en = capture_enable(rst_n, any_held);

  fpa_capture #(.W(N)) u_cap (
    .clk  (clk),
    .load (load_en),
    .d    (sync_q),
    .q    (held_q)
  );

  assign win_o    = held_q;
  assign locked_o = any_held;
endmodule

// File: rtl/first_press_arbiter_chk.sv
module first_press_arbiter_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] win_o,
  input logic         locked_o,
  input logic [N-1:0] sync_q,
  input logic         load_en
);
  // R2
  lock_matches_or_chk: assert property (@(posedge clk) locked_o == ($countones(win_o) != 0));

  // R1
  follow_while_open_chk: assert property (@(posedge clk) !rst_n |=> win_o == $past(sync_q));

  // R3
  unlocked_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |=> win_o == $past(sync_q));

  // R4
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> $stable(win_o));

  // R4
  no_load_when_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> !load_en);
endmodule

bind first_press_arbiter first_press_arbiter_chk #(.N(N)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .win_o    (win_o),
  .locked_o (locked_o),
  .sync_q   (sync_q),
  .load_en  (load_en)
);

// File: tb/first_press_arbiter_tb_top.sv
`timescale 1ns/1ps
module first_press_arbiter_tb_top;
  localparam int N  = 6;
  localparam int SS = 2;
  localparam int LAT = SS + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] press_i = '0;
  logic [N-1:0] win_o;
  logic         locked_o;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  first_press_arbiter #(.N(N), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst_n(rst_n), .press_i(press_i), .win_o(win_o), .locked_o(locked_o)
  );

  // Reference: delay line of sampled presses plus a frozen-or-open register.
  logic [N-1:0] pipe [LAT];
  logic [N-1:0] ref_win = '0;

  function automatic bit ref_lock(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !ref_lock(ref_win)) ref_win <= pipe[LAT-2];
    for (int s = LAT-2; s > 0; s--) pipe[s] <= pipe[s-1];
    pipe[0] <= press_i;
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (model_on) begin
        chk("R1/R3/R4 model win", win_o, ref_win);
        chk("R2 lock", {{(N-1){1'b0}}, locked_o}, {{(N-1){1'b0}}, ref_lock(ref_win)});
      end
    end
  endtask

  task automatic clear_open();
    rst_n = 1'b0; press_i = '0;
    step(LAT + 1);
    chk("R8 cleared win", win_o, '0);
    chk("R8 cleared lock", {{(N-1){1'b0}}, locked_o}, '0);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < LAT; s++) pipe[s] = '0;
    @(negedge clk);
    step(LAT + 2);
    // R8 reset state
    chk("R8 reset state win", win_o, '0);
    chk("R2 reset state lock", {{(N-1){1'b0}}, locked_o}, '0);
    rst_n = 1'b1;
    step(1);

    // R3 lone press with latency, then R4 later presses ignored
    press_i = 6'b001000;
    step(LAT - 1);
    chk("R3 not yet visible", win_o, '0);
    step(1);
    chk("R3 first press", win_o, 6'b001000);
    chk("R2 lock with winner", {{(N-1){1'b0}}, locked_o}, 6'b000001);
    press_i = 6'b111111;
    step(5);
    chk("R4 later presses ignored", win_o, 6'b001000);
    press_i = '0;
    step(4);
    chk("R4 release ignored", win_o, 6'b001000);

    clear_open();
    // R5 tie
    press_i = 6'b000101;
    step(LAT);
    chk("R5 tie both reported", win_o, 6'b000101);
    press_i = 6'b010000;
    step(3);
    chk("R4 tie frozen", win_o, 6'b000101);

    clear_open();
    // R6 one-cycle pulse
    press_i = 6'b100000;
    step(1);
    press_i = '0;
    step(LAT);
    chk("R6 pulse captured", win_o, 6'b100000);

    // R1 follow while open, R7 lock at release
    rst_n = 1'b0; press_i = 6'b000010;
    step(LAT);
    chk("R1 follows in reset", win_o, 6'b000010);
    press_i = 6'b000110;
    step(LAT);
    chk("R1 follows change", win_o, 6'b000110);
    rst_n = 1'b1; press_i = '0;
    step(2);
    chk("R7 frozen at release", win_o, 6'b000110);
    press_i = 6'b011000;
    step(LAT + 2);
    chk("R7 stays frozen", win_o, 6'b000110);

    // Random episodes against the reference model
    void'($urandom(32'h5eed1234));
    model_on = 1'b1;
    for (int ep = 0; ep < 300; ep++) begin
      rst_n = 1'b0;
      press_i = ($urandom % 4 == 0) ? N'($urandom) : '0;
      step(1 + ($urandom % 5));
      rst_n = 1'b1;
      for (int c = 0; c < 12; c++) begin
        if ($urandom % 3 == 0) press_i = N'($urandom);
        else if ($urandom % 2 == 0) press_i = '0;
        step(1);
      end
    end
    model_on = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule